// File: doc/BRIEF.md
# PWM Period and Pulse-Width Capture

This unit measures one digital PWM input in units of system clock cycles. The input is brought into the clock domain by two flip-flops and then passed through a selectable polarity. Once the first leading active edge after reset has been seen, the unit counts the cycles between successive leading edges (the period) and from each leading edge to the next trailing edge (the active pulse width).

The surrounding logic closes a measurement window by pulsing a strobe. On the cycle after each strobe, the unit presents a snapshot together with a one-cycle valid pulse. The snapshot holds the latest completed period and its pulse width, the smallest and largest pulse widths of periods that completed in the window, and two status flags. Counts that would run past full scale saturate and raise an overflow flag. If no period has completed yet, an inactive flag is raised. Either flag forces the period and pulse-width outputs to zero. Converting counts to hertz, duty ratio or seconds is left to the consumer.

Top module: `pwmcap_top`

## Requirements
- R1: With `invert_i` = 0 the active level is high: the leading edge is 0→1 and the trailing edge is 1→0. With `invert_i` = 1 the active level is low and the edge roles swap.
- R2: `period_o` reports the number of clock cycles between the two most recent leading edges.
- R3: `pulse_o` reports the number of clock cycles from the leading edge to the trailing edge of that same latest completed period, so it is always below `period_o` when both are valid.
- R4: No measurement starts before the first leading edge that follows reset. An input already active when reset is released does not start a measurement. Until a period completes, the inactive flag `inact_o` reads 1.
- R5: A snapshot is taken of the state in the cycle where `win_end_i` is 1. It appears on the outputs on the next cycle, along with `valid_o` = 1 for exactly that one cycle. Between strobes, all outputs hold their values.
- R6: `min_o` and `max_o` are the smallest and largest pulse widths among the periods that completed inside the window. A period that completes in the same cycle as the strobe counts toward the following window.
- R7: At each strobe the running maximum reloads to 0 and the running minimum reloads to full scale (2^CNT_W − 1). A window in which no period completed therefore reports `min_o` = 2^CNT_W − 1 and `max_o` = 0.
- R8: The period and pulse counters saturate at 2^CNT_W − 1. The overflow flag `ovf_o` is 1 when the running period count is saturated or the latest completed period was saturated. While `ovf_o` is 1, `period_o` and `pulse_o` read 0.
- R9: While `inact_o` is 1, `period_o` and `pulse_o` read 0.
- R10: During and just after reset, every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_i | input | 1 | Asynchronous PWM input |
| invert_i | input | 1 | 1 selects active-low polarity |
| win_end_i | input | 1 | One-cycle window-end strobe |
| valid_o | output | 1 | One-cycle pulse marking a new snapshot |
| period_o | output | CNT_W | Latest period in cycles |
| pulse_o | output | CNT_W | Active width of the latest period in cycles |
| min_o | output | CNT_W | Smallest pulse width in the closed window |
| max_o | output | CNT_W | Largest pulse width in the closed window |
| ovf_o | output | 1 | Period count saturated |
| inact_o | output | 1 | No completed period yet |

## Verification
The properties assume that `invert_i` is held steady between resets. They also assume that `win_end_i` is a clean synchronous pulse driven away from the clock edge. The stimulus therefore changes polarity only while reset is asserted and drives every input on the falling clock edge. `pwm_i` is driven as whole-cycle high and low runs of chosen lengths, so edges never fall between samples. The runs include a hold long enough to saturate a shortened counter, which the bench selects through the width parameter.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;

    localparam int unsigned CNT_W_DEFAULT = 20;
    localparam int unsigned SYNC_STAGES   = 2;
    // cycles after reset before edge history is trustworthy
    localparam int unsigned PRIME_CYCLES  = SYNC_STAGES + 1;

    typedef struct packed {
        logic level;   // polarity-corrected active level
        logic lead;    // leading (activating) edge
        logic trail;   // trailing (deactivating) edge
    } edge_evt_t;

    typedef enum logic [1:0] {
        ST_OK       = 2'b00,
        ST_OVERFLOW = 2'b01,
        ST_INACTIVE = 2'b10
    } meas_state_e;

endpackage

// File: rtl/pwmcap_edge.sv
module pwmcap_edge
    import pwmcap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    input  logic      invert,
    output edge_evt_t evt
);
    logic [SYNC_STAGES-1:0]  sync_q;
    logic [PRIME_CYCLES-1:0] fill_q;
    logic                    act_d;
    logic                    act;
    logic                    primed;

    assign act    = sync_q[SYNC_STAGES-1] ^ invert;
    assign primed = fill_q[PRIME_CYCLES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            fill_q <= '0;
            act_d  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            fill_q <= {fill_q[PRIME_CYCLES-2:0], 1'b1};
            act_d  <= act;
        end
    end

    always_comb begin
        evt.level = act;
        evt.lead  = primed & act & ~act_d;
        evt.trail = primed & ~act & act_d;
    end
endmodule

// File: rtl/pwmcap_meter.sv
module pwmcap_meter
    import pwmcap_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  edge_evt_t        evt,
    output logic             done,
    output logic [CNT_W-1:0] done_pw,
    output logic [CNT_W-1:0] last_per,
    output logic [CNT_W-1:0] last_pw,
    output logic             run_sat
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    logic             armed;
    logic [CNT_W-1:0] per_cnt;
    logic [CNT_W-1:0] pw_cnt;
    logic [CNT_W-1:0] cur_pw;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            per_cnt  <= '0;
            pw_cnt   <= '0;
            cur_pw   <= '0;
            last_per <= '0;
            last_pw  <= '0;
        end else begin
            if (evt.lead) begin
                if (armed) begin
                    last_per <= per_cnt;
                    last_pw  <= cur_pw;
                end
                armed   <= 1'b1;
                per_cnt <= CNT_W'(1);
                pw_cnt  <= CNT_W'(1);
            end else begin
                if (armed && per_cnt != FULL)
                    per_cnt <= per_cnt + CNT_W'(1);
                if (armed && evt.level && pw_cnt != FULL)
                    pw_cnt <= pw_cnt + CNT_W'(1);
            end
            if (evt.trail && armed)
                cur_pw <= pw_cnt;
        end
    end

    assign done    = evt.lead & armed;
    assign done_pw = cur_pw;
    assign run_sat = armed & (per_cnt == FULL);
endmodule

// File: rtl/pwmcap_window.sv
module pwmcap_window
    import pwmcap_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             done,
    input  logic [CNT_W-1:0] done_pw,
    input  logic [CNT_W-1:0] last_per,
    input  logic [CNT_W-1:0] last_pw,
    input  logic             run_sat,
    output logic             valid_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] pulse_o,
    output logic [CNT_W-1:0] min_o,
    output logic [CNT_W-1:0] max_o,
    output logic             ovf_o,
    output logic             inact_o
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    logic [CNT_W-1:0] min_q, max_q;
    logic [CNT_W-1:0] base_min, base_max;
    logic [CNT_W-1:0] next_min, next_max;
    meas_state_e      state;

    always_comb begin
        base_min = strobe ? FULL : min_q;
        base_max = strobe ? '0   : max_q;
        next_min = (done && done_pw < base_min) ? done_pw : base_min;
        next_max = (done && done_pw > base_max) ? done_pw : base_max;
        if (run_sat || last_per == FULL)
            state = ST_OVERFLOW;
        else if (last_per == '0)
            state = ST_INACTIVE;
        else
            state = ST_OK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            min_q    <= FULL;
            max_q    <= '0;
            valid_o  <= 1'b0;
            period_o <= '0;
            pulse_o  <= '0;
            min_o    <= '0;
            max_o    <= '0;
            ovf_o    <= 1'b0;
            inact_o  <= 1'b0;
        end else begin
            min_q   <= next_min;
            max_q   <= next_max;
            valid_o <= strobe;
            if (strobe) begin
                ovf_o    <= (state == ST_OVERFLOW);
                inact_o  <= (state == ST_INACTIVE);
                period_o <= (state == ST_OK) ? last_per : '0;
                pulse_o  <= (state == ST_OK) ? last_pw  : '0;
                min_o    <= min_q;
                max_o    <= max_q;
            end
        end
    end
endmodule

// File: rtl/pwmcap_top.sv
module pwmcap_top
    import pwmcap_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_i,
    input  logic             invert_i,
    input  logic             win_end_i,
    output logic             valid_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] pulse_o,
    output logic [CNT_W-1:0] min_o,
    output logic [CNT_W-1:0] max_o,
    output logic             ovf_o,
    output logic             inact_o
);
    edge_evt_t        evt;
    logic             done;
    logic [CNT_W-1:0] done_pw;
    logic [CNT_W-1:0] last_per;
    logic [CNT_W-1:0] last_pw;
    logic             run_sat;

    pwmcap_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin    (pwm_i),
        .invert (invert_i),
        .evt    (evt)
    );

    pwmcap_meter #(.CNT_W(CNT_W)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .done     (done),
        .done_pw  (done_pw),
        .last_per (last_per),
        .last_pw  (last_pw),
        .run_sat  (run_sat)
    );

    pwmcap_window #(.CNT_W(CNT_W)) u_window (
        .clk      (clk),
        .rst      (rst),
        .strobe   (win_end_i),
        .done     (done),
        .done_pw  (done_pw),
        .last_per (last_per),
        .last_pw  (last_pw),
        .run_sat  (run_sat),
        .valid_o  (valid_o),
        .period_o (period_o),
        .pulse_o  (pulse_o),
        .min_o    (min_o),
        .max_o    (max_o),
        .ovf_o    (ovf_o),
        .inact_o  (inact_o)
    );
endmodule

// File: rtl/pwmcap_chk.sv
module pwmcap_chk #(
    parameter int unsigned CNT_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             win_end_i,
    input logic             valid_o,
    input logic [CNT_W-1:0] period_o,
    input logic [CNT_W-1:0] pulse_o,
    input logic [CNT_W-1:0] min_o,
    input logic [CNT_W-1:0] max_o,
    input logic             ovf_o,
    input logic             inact_o
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    // R5
    strobe_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
        win_end_i |=> valid_o);

    // R5
    valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(win_end_i));

    // R5
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !win_end_i |=> ($stable(period_o) && $stable(pulse_o) &&
                        $stable(min_o) && $stable(max_o) &&
                        $stable(ovf_o) && $stable(inact_o)));

    // R8
    ovf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && ovf_o) |-> (period_o == '0 && pulse_o == '0));

    // R9
    inact_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && inact_o) |-> (period_o == '0 && pulse_o == '0));

    // R3
    pulse_below_period_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ovf_o && !inact_o) |-> (pulse_o < period_o));

    // R7
    extrema_order_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ((min_o <= max_o) || (min_o == FULL && max_o == '0)));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!valid_o && period_o == '0 && min_o == '0));
endmodule

bind pwmcap_top pwmcap_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .win_end_i (win_end_i),
    .valid_o   (valid_o),
    .period_o  (period_o),
    .pulse_o   (pulse_o),
    .min_o     (min_o),
    .max_o     (max_o),
    .ovf_o     (ovf_o),
    .inact_o   (inact_o)
);

// File: tb/pwmcap_top_test.sv
module pwmcap_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 10;
    localparam int FULL       = (1 << W) - 1;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pwm = 1'b0;
    logic         inv = 1'b0;
    logic         win = 1'b0;
    logic         valid_o, ovf_o, inact_o;
    logic [W-1:0] period_o, pulse_o, min_o, max_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwmcap_top #(.CNT_W(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .pwm_i     (pwm),
        .invert_i  (inv),
        .win_end_i (win),
        .valid_o   (valid_o),
        .period_o  (period_o),
        .pulse_o   (pulse_o),
        .min_o     (min_o),
        .max_o     (max_o),
        .ovf_o     (ovf_o),
        .inact_o   (inact_o)
    );

    // behavioural reference, advanced on every rising edge
    int m_q[$];
    int m_age, m_prev, m_armed, m_pc, m_wc, m_cpw, m_lp, m_lpw, m_mn, m_mx;
    int e_valid, e_per, e_pw, e_min, e_max, e_ovf, e_ina;

    always @(posedge clk) begin
        int lvl, lead, trail, done, bmn, bmx, bad_o, bad_i;
        if (rst) begin
            m_q = '{0, 0};
            m_age = 0; m_prev = 0; m_armed = 0; m_pc = 0; m_wc = 0;
            m_cpw = 0; m_lp = 0; m_lpw = 0; m_mn = FULL; m_mx = 0;
            e_valid = 0; e_per = 0; e_pw = 0; e_min = 0; e_max = 0;
            e_ovf = 0; e_ina = 0;
        end else begin
            lvl   = m_q[0] ^ int'(inv);
            lead  = (m_age >= 3 && lvl == 1 && m_prev == 0) ? 1 : 0;
            trail = (m_age >= 3 && lvl == 0 && m_prev == 1) ? 1 : 0;
            done  = lead & m_armed;
            e_valid = int'(win);
            if (win) begin
                bad_o = ((m_armed && m_pc == FULL) || m_lp == FULL) ? 1 : 0;
                bad_i = (bad_o == 0 && m_lp == 0) ? 1 : 0;
                e_ovf = bad_o; e_ina = bad_i;
                e_per = (bad_o || bad_i) ? 0 : m_lp;
                e_pw  = (bad_o || bad_i) ? 0 : m_lpw;
                e_min = m_mn; e_max = m_mx;
            end
            bmn = win ? FULL : m_mn;
            bmx = win ? 0 : m_mx;
            if (done) begin
                if (m_cpw < bmn) bmn = m_cpw;
                if (m_cpw > bmx) bmx = m_cpw;
            end
            m_mn = bmn; m_mx = bmx;
            if (trail && m_armed) m_cpw = m_wc;
            if (lead) begin
                if (m_armed) begin m_lp = m_pc; m_lpw = m_cpw; end
                m_armed = 1; m_pc = 1; m_wc = 1;
            end else begin
                if (m_armed && m_pc < FULL) m_pc++;
                if (m_armed && lvl == 1 && m_wc < FULL) m_wc++;
            end
            m_prev = lvl;
            m_q.push_back(int'(pwm));
            void'(m_q.pop_front());
            if (m_age < 3) m_age++;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (!finished) begin
            check("R5",  "valid",  int'(valid_o),  e_valid);
            check("R2",  "period", int'(period_o), e_per);
            check("R3",  "pulse",  int'(pulse_o),  e_pw);
            check("R6",  "min",    int'(min_o),    e_min);
            check("R6",  "max",    int'(max_o),    e_max);
            check("R8",  "ovf",    int'(ovf_o),    e_ovf);
            check("R9",  "inact",  int'(inact_o),  e_ina);
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int hi, int lo);
        pwm = 1'b1; wait_cyc(hi);
        pwm = 1'b0; wait_cyc(lo);
    endtask

    // raise win for one cycle; returns at the negedge where the snapshot is visible
    task automatic close_window();
        @(negedge clk) win = 1'b1;
        @(negedge clk) win = 1'b0;
    endtask

    task automatic do_reset(logic pin_level, logic pol);
        @(negedge clk);
        rst = 1'b1; pwm = pin_level; inv = pol; win = 1'b0;
        wait_cyc(3);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R10 and R4: pin already active while reset is released
        do_reset(1'b1, 1'b0);
        check("R10", "valid after reset", int'(valid_o), 0);
        check("R10", "period after reset", int'(period_o), 0);
        check("R10", "min after reset", int'(min_o), 0);
        wait_cyc(10);
        close_window();
        check("R4", "inactive before first lead", int'(inact_o), 1);
        check("R9", "period zero while inactive", int'(period_o), 0);
        check("R7", "empty window min", int'(min_o), FULL);
        check("R7", "empty window max", int'(max_o), 0);
        @(negedge clk);
        check("R5", "valid lasts one cycle", int'(valid_o), 0);

        // R2 R3: steady 3 high / 7 low
        pwm = 1'b0; wait_cyc(5);
        for (int i = 0; i < 5; i++) pulse(3, 7);
        pwm = 1'b1; wait_cyc(5);
        close_window();
        check("R2", "period 10", int'(period_o), 10);
        check("R3", "pulse 3", int'(pulse_o), 3);
        check("R6", "min 3", int'(min_o), 3);
        check("R6", "max 3", int'(max_o), 3);
        check("R4", "active after periods", int'(inact_o), 0);

        // R6: varying widths 7 (carried), 2, 5, 4 in one window
        pwm = 1'b0; wait_cyc(3);
        pulse(2, 8); pulse(5, 5); pulse(4, 6);
        pwm = 1'b1; wait_cyc(5);
        close_window();
        check("R6", "min over window", int'(min_o), 2);
        check("R6", "max over window", int'(max_o), 7);
        check("R2", "latest period", int'(period_o), 10);
        check("R3", "latest pulse", int'(pulse_o), 4);

        // R7: window without completion
        pwm = 1'b0; wait_cyc(100);
        close_window();
        check("R7", "default min", int'(min_o), FULL);
        check("R7", "default max", int'(max_o), 0);
        check("R2", "period held", int'(period_o), 10);

        // R8: hold inactive past full scale
        wait_cyc(FULL + 80);
        close_window();
        check("R8", "overflow flag", int'(ovf_o), 1);
        check("R8", "period forced zero", int'(period_o), 0);
        check("R8", "pulse forced zero", int'(pulse_o), 0);

        // recovery
        for (int i = 0; i < 3; i++) pulse(3, 7);
        pwm = 1'b1; wait_cyc(5);
        close_window();
        check("R8", "overflow cleared", int'(ovf_o), 0);
        check("R2", "period after recovery", int'(period_o), 10);
        check("R6", "min after recovery", int'(min_o), 3);
        check("R6", "max includes saturated period pulse", int'(max_o), 7);

        // R1: active-low input, idle high, low for 4 out of 12
        do_reset(1'b1, 1'b1);
        wait_cyc(5);
        for (int i = 0; i < 4; i++) begin
            pwm = 1'b0; wait_cyc(4);
            pwm = 1'b1; wait_cyc(8);
        end
        pwm = 1'b0; wait_cyc(5);
        close_window();
        check("R1", "inverted period", int'(period_o), 12);
        check("R1", "inverted pulse", int'(pulse_o), 4);
        check("R1", "inverted min", int'(min_o), 4);
        check("R1", "inverted max", int'(max_o), 4);

        // R6: completion coinciding with the strobe goes to the next window
        pwm = 1'b1; wait_cyc(8);
        pwm = 1'b0;
        @(negedge clk); @(negedge clk);
        win = 1'b1;
        @(negedge clk) win = 1'b0;
        wait_cyc(20);
        close_window();
        wait_cyc(3);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule